// File: doc/BRIEF.md
# Cascade PID Compensator with Identification Injection

This block is the per-cycle control law of a digitally regulated switching converter. Once per switching period it receives a signed error sample and produces a new duty command for the pulse-width modulator. The law is written in cascade form: two first-order numerator sections, each of the form x[n] − z·x[n−1], followed by a gain and an accumulating pole at z = 1. This is the same law as a backward-Euler proportional/integral/derivative filter, expressed as a gain and two zero locations. Loading zero coefficients of zero turns it into a plain integrator.

Coefficients arrive through a small write port into shadow registers. A commit strobe arms them, and they become active at the next accepted sample, so a tuning run changes the loop in one clean step and the loop then holds the new values until the next commit. For frequency-response measurement, an identification input freezes the compensator: the accumulator and both section histories keep their values. In that mode the duty command becomes the frozen output plus or minus a programmable amplitude, with the sign chosen by an external binary stimulus bit. Every duty value is clamped to the modulator range.

The control sequence walks five named states. IDLE goes to ZERO_A on an accepted sample. ZERO_A goes to ZERO_B, ZERO_B goes to INTEG, INTEG goes to DRIVE, and DRIVE returns to IDLE. Each of these four transitions is unconditional.

Top module: `cascade_pid`

## Requirements
- R1: While reset is held and after it is released, with no sample yet, duty_out is 0 and duty_valid is 0.
- R2: A strobe on smp_valid is accepted only in IDLE. The new duty_out and a one-cycle duty_valid pulse appear after the fifth rising edge, counting the accepting edge as the first. Strobes while a sample is in flight are ignored and change neither that result nor any later one.
- R3: In normal mode each sample computes a = e − floor(zA·e_prev/2^16), then b = a − floor(zB·a_prev/2^16), then acc = acc + floor(K·b/2^8). Here zA is the coefficient at select 0 and zB the coefficient at select 1, both unsigned with 16 fraction bits. K is the gain at select 2, unsigned with 8 fraction bits. The duty_out value is the new acc.
- R4: With both zero coefficients at 0 the output is a pure integrator: acc = acc + floor(K·e/2^8).
- R5: The accumulator saturates at 0 and at 4095 and never stores a value outside that range. After saturation, an error of opposite sign moves the output away from the bound on the very next sample.
- R6: Writes on the configuration port without a commit do not change the results of later samples.
- R7: After a commit strobe, the shadow values become active at the next accepted sample and are used for that sample. A commit during an in-flight sample does not affect that sample. The accumulator and section histories carry across the change.
- R8: With ident_en high at acceptance, the accumulator and both histories stay unchanged. duty_out is acc + amp when stim_bit is 1 and acc − amp when stim_bit is 0, where amp is the 12-bit amplitude at select 3.
- R9: The identification duty is clamped to 0 and 4095.
- R10: A normal sample after identification samples continues from the state as it stood before the identification samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | New error sample strobe, once per switching period |
| err_in | input | ERR_W (9) | Signed error sample |
| cfg_we | input | 1 | Shadow register write enable |
| cfg_sel | input | 2 | Select: 0 zero A, 1 zero B, 2 gain, 3 stimulus amplitude |
| cfg_wdata | input | CFG_W (16) | Write data |
| cfg_commit | input | 1 | Arms shadow values for the next sample boundary |
| ident_en | input | 1 | Identification mode, captured with the sample |
| stim_bit | input | 1 | Binary stimulus, captured with the sample |
| duty_out | output | DUTY_W (12) | Clamped duty command |
| duty_valid | output | 1 | One-cycle pulse when duty_out is updated |

## Verification
Each result follows its accepting edge by exactly five rising edges: one edge captures the sample, then ZERO_A, ZERO_B, INTEG and DRIVE each add one register stage. The bench drives the strobe at a falling edge, counts five rising edges and samples at the next falling edge, where duty_valid must be high. For the pulse-width check it samples once more a cycle later. Expected values come from a bench-side model of the difference equations, including the commit-at-boundary and freeze rules. Stray strobes and mid-flight commits are placed inside that five-edge window so that their absence of effect shows in the same result.

// File: rtl/pidc_pkg.sv
package pidc_pkg;

    // Control sequence of one sample through the cascade
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ZERO_A = 3'd1,
        ST_ZERO_B = 3'd2,
        ST_INTEG  = 3'd3,
        ST_DRIVE  = 3'd4
    } pidc_state_e;

    // Configuration port selects
    typedef enum logic [1:0] {
        SEL_ZERO_A = 2'd0,
        SEL_ZERO_B = 2'd1,
        SEL_GAIN   = 2'd2,
        SEL_AMP    = 2'd3
    } pidc_sel_e;

endpackage

// File: rtl/pidc_cfg_bank.sv
module pidc_cfg_bank
    import pidc_pkg::*;
#(
    parameter int ZW    = 16,
    parameter int KW    = 16,
    parameter int DW    = 12,
    parameter int CFG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             cfg_commit,
    input  logic             apply,
    output logic [ZW-1:0]    act_za,
    output logic [ZW-1:0]    act_zb,
    output logic [KW-1:0]    act_k,
    output logic [DW-1:0]    act_amp
);

    logic [ZW-1:0] sh_za, sh_zb;
    logic [KW-1:0] sh_k;
    logic [DW-1:0] sh_amp;
    logic          armed;

    // Shadow registers: written freely, never used directly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_za  <= '0;
            sh_zb  <= '0;
            sh_k   <= '0;
            sh_amp <= '0;
        end else if (cfg_we) begin
            unique case (pidc_sel_e'(cfg_sel))
                SEL_ZERO_A: sh_za  <= cfg_wdata[ZW-1:0];
                SEL_ZERO_B: sh_zb  <= cfg_wdata[ZW-1:0];
                SEL_GAIN:   sh_k   <= cfg_wdata[KW-1:0];
                SEL_AMP:    sh_amp <= cfg_wdata[DW-1:0];
            endcase
        end
    end

    // A commit arms the transfer; the sample boundary consumes it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else begin
            if (apply)      armed <= 1'b0;
            if (cfg_commit) armed <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_za  <= '0;
            act_zb  <= '0;
            act_k   <= '0;
            act_amp <= '0;
        end else if (apply && armed) begin
            act_za  <= sh_za;
            act_zb  <= sh_zb;
            act_k   <= sh_k;
            act_amp <= sh_amp;
        end
    end

    generate
        if (CFG_W > DW) begin : g_spare
            logic unused_amp_hi;
            assign unused_amp_hi = ^cfg_wdata[CFG_W-1:DW];
        end
    endgenerate

endmodule

// File: rtl/pidc_zero_stage.sv
module pidc_zero_stage #(
    parameter int IN_W  = 9,
    parameter int OUT_W = 11,
    parameter int ZW    = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic signed [IN_W-1:0]  x,
    input  logic [ZW-1:0]           coef,
    output logic signed [OUT_W-1:0] y
);

    localparam int PW = IN_W + ZW + 1;

    logic signed [IN_W-1:0]  x_prev;
    logic signed [PW-1:0]    prod;
    logic signed [PW-1:0]    scaled;
    logic signed [OUT_W-1:0] y_next;

    // y[n] = x[n] - floor(coef * x[n-1] / 2^ZW)
    assign prod   = PW'($signed({1'b0, coef})) * PW'(x_prev);
    assign scaled = prod >>> ZW;
    assign y_next = OUT_W'(x) - OUT_W'(scaled);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_prev <= '0;
            y      <= '0;
        end else if (en) begin
            x_prev <= x;
            y      <= y_next;
        end
    end

endmodule

// File: rtl/pidc_integrator.sv
module pidc_integrator #(
    parameter int IN_W = 12,
    parameter int KW   = 16,
    parameter int KF   = 8,
    parameter int DW   = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic signed [IN_W-1:0] s,
    input  logic [KW-1:0]          gain,
    output logic [DW-1:0]          acc
);

    localparam int PW = IN_W + KW + 1;
    localparam int SW = PW + 1;
    localparam logic signed [SW-1:0] TOP = SW'((1 << DW) - 1);

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] step;
    logic signed [SW-1:0] sum;
    logic [DW-1:0]        acc_next;

    assign prod = PW'(s) * PW'($signed({1'b0, gain}));
    assign step = prod >>> KF;
    assign sum  = SW'($signed({1'b0, acc})) + SW'(step);

    // Saturating accumulate: holding at a bound is the anti-windup
    always_comb begin
        if (sum < 0)        acc_next = '0;
        else if (sum > TOP) acc_next = TOP[DW-1:0];
        else                acc_next = sum[DW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  acc <= '0;
        else if (en) acc <= acc_next;
    end

endmodule

// File: rtl/pidc_inject.sv
module pidc_inject #(
    parameter int DW = 12
) (
    input  logic          ident,
    input  logic          stim,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] amp,
    output logic [DW-1:0] duty
);

    localparam int XW = DW + 2;
    localparam logic signed [XW-1:0] TOP = XW'((1 << DW) - 1);

    logic signed [XW-1:0] hold, delta, sum;

    assign hold  = $signed({2'b00, acc});
    assign delta = stim ? $signed({2'b00, amp}) : -$signed({2'b00, amp});
    assign sum   = hold + delta;

    always_comb begin
        if (!ident)         duty = acc;
        else if (sum < 0)   duty = '0;
        else if (sum > TOP) duty = TOP[DW-1:0];
        else                duty = sum[DW-1:0];
    end

endmodule

// File: rtl/cascade_pid.sv
module cascade_pid
    import pidc_pkg::*;
#(
    parameter int ERR_W     = 9,
    parameter int DUTY_W    = 12,
    parameter int ZERO_FRAC = 16,
    parameter int GAIN_W    = 16,
    parameter int GAIN_FRAC = 8,
    parameter int CFG_W     = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic signed [ERR_W-1:0] err_in,
    input  logic                    cfg_we,
    input  logic [1:0]              cfg_sel,
    input  logic [CFG_W-1:0]        cfg_wdata,
    input  logic                    cfg_commit,
    input  logic                    ident_en,
    input  logic                    stim_bit,
    output logic [DUTY_W-1:0]       duty_out,
    output logic                    duty_valid
);

    localparam int S1_W = ERR_W + 2;
    localparam int S2_W = ERR_W + 3;

    pidc_state_e state, state_nx;

    logic                    take;
    logic signed [ERR_W-1:0] e_cur;
    logic                    ident_q, stim_q;
    logic [ZERO_FRAC-1:0]    act_za, act_zb;
    logic [GAIN_W-1:0]       act_k;
    logic [DUTY_W-1:0]       act_amp;
    logic signed [S1_W-1:0]  sec_a;
    logic signed [S2_W-1:0]  sec_b;
    logic [DUTY_W-1:0]       acc_q;
    logic [DUTY_W-1:0]       duty_nx;

    assign take = smp_valid && (state == ST_IDLE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (take) state_nx = ST_ZERO_A;
            ST_ZERO_A: state_nx = ST_ZERO_B;
            ST_ZERO_B: state_nx = ST_INTEG;
            ST_INTEG:  state_nx = ST_DRIVE;
            ST_DRIVE:  state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Sample capture at the boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_cur   <= '0;
            ident_q <= 1'b0;
            stim_q  <= 1'b0;
        end else if (take) begin
            e_cur   <= err_in;
            ident_q <= ident_en;
            stim_q  <= stim_bit;
        end
    end

    pidc_cfg_bank #(
        .ZW(ZERO_FRAC), .KW(GAIN_W), .DW(DUTY_W), .CFG_W(CFG_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_commit(cfg_commit), .apply(take),
        .act_za(act_za), .act_zb(act_zb), .act_k(act_k), .act_amp(act_amp)
    );

    pidc_zero_stage #(
        .IN_W(ERR_W), .OUT_W(S1_W), .ZW(ZERO_FRAC)
    ) u_zero_a (
        .clk(clk), .rst_n(rst_n),
        .en((state == ST_ZERO_A) && !ident_q),
        .x(e_cur), .coef(act_za), .y(sec_a)
    );

    pidc_zero_stage #(
        .IN_W(S1_W), .OUT_W(S2_W), .ZW(ZERO_FRAC)
    ) u_zero_b (
        .clk(clk), .rst_n(rst_n),
        .en((state == ST_ZERO_B) && !ident_q),
        .x(sec_a), .coef(act_zb), .y(sec_b)
    );

    pidc_integrator #(
        .IN_W(S2_W), .KW(GAIN_W), .KF(GAIN_FRAC), .DW(DUTY_W)
    ) u_integ (
        .clk(clk), .rst_n(rst_n),
        .en((state == ST_INTEG) && !ident_q),
        .s(sec_b), .gain(act_k), .acc(acc_q)
    );

    pidc_inject #(
        .DW(DUTY_W)
    ) u_inject (
        .ident(ident_q), .stim(stim_q), .acc(acc_q), .amp(act_amp), .duty(duty_nx)
    );

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_out   <= '0;
            duty_valid <= 1'b0;
        end else begin
            duty_valid <= (state == ST_DRIVE);
            if (state == ST_DRIVE) duty_out <= duty_nx;
        end
    end

endmodule

// File: rtl/pidc_checker.sv
module pidc_checker
    import pidc_pkg::*;
#(
    parameter int ZW = 16,
    parameter int KW = 16,
    parameter int DW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          take,
    input pidc_state_e   state,
    input logic          ident_q,
    input logic [DW-1:0] acc_q,
    input logic [DW-1:0] duty_out,
    input logic          duty_valid,
    input logic [ZW-1:0] act_za,
    input logic [ZW-1:0] act_zb,
    input logic [KW-1:0] act_k,
    input logic [DW-1:0] act_amp
);

    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        duty_valid |-> $past(take, 5));

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        duty_valid |=> !duty_valid);

    a_r2_duty_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(duty_out) |-> duty_valid);

    a_r3_acc_step_only: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_INTEG) |=> $stable(acc_q));

    a_r7_commit_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> ($stable(act_za) && $stable(act_zb) && $stable(act_k) && $stable(act_amp)));

    a_r8_ident_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (ident_q && (state != ST_IDLE)) |=> $stable(acc_q));

endmodule

bind cascade_pid pidc_checker #(
    .ZW(ZERO_FRAC), .KW(GAIN_W), .DW(DUTY_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .take(take), .state(state), .ident_q(ident_q),
    .acc_q(acc_q), .duty_out(duty_out), .duty_valid(duty_valid),
    .act_za(act_za), .act_zb(act_zb), .act_k(act_k), .act_amp(act_amp)
);

// File: tb/sim_cascade_pid.sv
module sim_cascade_pid;

    localparam int ERR_W  = 9;
    localparam int DUTY_W = 12;
    localparam int CFG_W  = 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                    rst_n = 1'b0;
    logic                    smp_valid = 1'b0;
    logic signed [ERR_W-1:0] err_in = '0;
    logic                    cfg_we = 1'b0;
    logic [1:0]              cfg_sel = '0;
    logic [CFG_W-1:0]        cfg_wdata = '0;
    logic                    cfg_commit = 1'b0;
    logic                    ident_en = 1'b0;
    logic                    stim_bit = 1'b0;
    logic [DUTY_W-1:0]       duty_out;
    logic                    duty_valid;

    cascade_pid u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .err_in(err_in),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_commit(cfg_commit), .ident_en(ident_en), .stim_bit(stim_bit),
        .duty_out(duty_out), .duty_valid(duty_valid)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference model of the requirements
    longint m_acc = 0, m_e1 = 0, m_a1 = 0;
    longint a_za = 0, a_zb = 0, a_k = 0, a_amp = 0;
    longint s_za = 0, s_zb = 0, s_k = 0, s_amp = 0;
    bit     m_armed = 1'b0;

    function automatic longint clamp(longint v);
        if (v < 0)    return 0;
        if (v > 4095) return 4095;
        return v;
    endfunction

    function automatic longint model_step(longint e, bit id, bit st);
        longint a, b;
        if (m_armed) begin
            a_za = s_za; a_zb = s_zb; a_k = s_k; a_amp = s_amp;
            m_armed = 1'b0;
        end
        if (id) return clamp(m_acc + (st ? a_amp : -a_amp));
        a = e - ((a_za * m_e1) >>> 16);
        b = a - ((a_zb * m_a1) >>> 16);
        m_e1  = e;
        m_a1  = a;
        m_acc = clamp(m_acc + ((a_k * b) >>> 8));
        return m_acc;
    endfunction

    task automatic check(string req, longint act, longint exp, string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(int sel, int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = CFG_W'(val);
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            0: s_za = val;
            1: s_zb = val;
            2: s_k = val;
            default: s_amp = val & 12'hFFF;
        endcase
    endtask

    task automatic commit_now();
        @(negedge clk);
        cfg_commit = 1'b1;
        @(negedge clk);
        cfg_commit = 1'b0;
        m_armed = 1'b1;
    endtask

    // One sample: result due after the fifth rising edge
    task automatic sample(int e, bit id, bit st, string req);
        longint exp;
        exp = model_step(e, id, st);
        @(negedge clk);
        smp_valid = 1'b1; err_in = ERR_W'(e); ident_en = id; stim_bit = st;
        @(posedge clk);
        #1 smp_valid = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(req, duty_valid, 1, "duty_valid");
        check(req, duty_out, exp, "duty_out");
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", duty_out, 0, "duty_out in reset");
        check("R1", duty_valid, 0, "duty_valid in reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", duty_out, 0, "duty_out after reset");
        check("R1", duty_valid, 0, "duty_valid after reset");
    endtask

    task automatic t_integral();
        wr(0, 0); wr(1, 0); wr(2, 16'h0200);
        commit_now();
        sample(10, 0, 0, "R4");
        check("R4", duty_out, 20, "hand value step 1");
        sample(10, 0, 0, "R4");
        sample(10, 0, 0, "R4");
        check("R4", duty_out, 60, "hand value step 3");
        sample(-7, 0, 0, "R4");
        check("R4", duty_out, 46, "hand value negative");
        @(negedge clk);
        check("R2", duty_valid, 0, "pulse width one cycle");
    endtask

    task automatic t_impulse();
        wr(0, 16'h8000); wr(1, 16'h4000); wr(2, 16'h0100);
        commit_now();
        sample(0, 0, 0, "R3");
        sample(100, 0, 0, "R3");
        sample(0, 0, 0, "R3");
        sample(0, 0, 0, "R3");
        sample(-37, 0, 0, "R3");
        sample(55, 0, 0, "R3");
        sample(-201, 0, 0, "R3");
    endtask

    task automatic t_saturate();
        wr(0, 0); wr(1, 0); wr(2, 16'h4000);
        commit_now();
        sample(255, 0, 0, "R5");
        sample(255, 0, 0, "R5");
        check("R5", duty_out, 4095, "upper bound");
        sample(-1, 0, 0, "R5");
        check("R5", duty_out, 4031, "no windup above");
        sample(-255, 0, 0, "R5");
        sample(-255, 0, 0, "R5");
        check("R5", duty_out, 0, "lower bound");
        sample(1, 0, 0, "R5");
        check("R5", duty_out, 64, "no windup below");
    endtask

    task automatic t_shadow();
        wr(2, 16'h0100);
        wr(0, 16'hC000);
        sample(2, 0, 0, "R6");
        check("R6", duty_out, 192, "old gain still active");
    endtask

    task automatic t_commit_mid();
        longint exp;
        exp = model_step(3, 1'b0, 1'b0);
        @(negedge clk);
        smp_valid = 1'b1; err_in = ERR_W'(3); ident_en = 1'b0;
        @(posedge clk);
        #1 smp_valid = 1'b0; cfg_commit = 1'b1;
        @(posedge clk);
        #1 cfg_commit = 1'b0;
        m_armed = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7", duty_out, exp, "mid-flight commit ignored");
        sample(4, 0, 0, "R7");
        sample(-9, 0, 0, "R7");
    endtask

    task automatic t_busy();
        longint exp;
        exp = model_step(20, 1'b0, 1'b0);
        @(negedge clk);
        smp_valid = 1'b1; err_in = ERR_W'(20); ident_en = 1'b0;
        @(posedge clk);
        #1 err_in = ERR_W'(-200);
        repeat (2) @(posedge clk);
        #1 smp_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R2", duty_out, exp, "busy strobe ignored");
        @(negedge clk);
        check("R2", duty_valid, 0, "no second result");
        sample(-5, 0, 0, "R2");
    endtask

    task automatic t_ident();
        wr(3, 300);
        commit_now();
        sample(6, 0, 0, "R8");
        sample(100, 1, 1, "R8");
        sample(-100, 1, 0, "R8");
        wr(3, 4000);
        commit_now();
        sample(0, 1, 1, "R9");
        check("R9", duty_out, 4095, "upper clamp");
        sample(0, 1, 0, "R9");
        check("R9", duty_out, 0, "lower clamp");
        sample(7, 0, 0, "R10");
        sample(-3, 0, 0, "R10");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_integral();
        t_impulse();
        t_saturate();
        t_shadow();
        t_commit_mid();
        t_busy();
        t_ident();
        repeat (4) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

endmodule